// File: doc/BRIEF.md
# Reloadable Overflow Timer with Watchdog and Pin Waveform

This block is an 8-bit up-counter that advances by one on each cycle where an external count-enable strobe is high. The strobe would normally come from a prescaler outside the block. When the count passes its maximum, the counter restarts from a value that software has written. The overflow raises a sticky interrupt flag. If the watchdog bit is set, the overflow also raises a one-cycle system reset request. Software keeps the watchdog quiet by restarting the counter before it reaches its maximum.

The same overflow event drives a single output pin. The pin can toggle, be forced low, or be forced high at each overflow. It can also carry a variable-duty pulse that compares the running count against the programmed value. A small write/read register bus carries the output mode, the pulse polarity, the reload value (written as two nibbles and committed together), the watchdog bit, the flag clear and the counter restart. The same bus reads back the committed reload and the live count.

Top module: `reload_timer`

## Requirements
- R1: The count rises by exactly one on each clock edge where `cntEn` is high and no restart is written. With `cntEn` low, the count holds. The count can be read with the low nibble at address 5 and the high nibble at address 6.
- R2: On an edge with `cntEn` high and the count at 8'hFF, an overflow occurs. The count loads the committed reload value, or 0 in PWM mode. Writing address 4 with bit 2 set loads the count the same way. This restart takes priority over counting and suppresses the overflow in that cycle.
- R3: A write to address 2 only stages the low nibble. A write to address 3 commits {wrData, staged nibble} as the reload value. Reads of addresses 2 and 3 return the committed nibbles. If a commit falls on an overflow edge, the counter loads the value committed before that edge.
- R4: Each overflow sets `irqFlag`, and the flag stays set. Writing address 4 with bit 1 set clears it. When a clear and an overflow fall on the same edge, the flag stays set. Address 4 reads back {2'b00, irqFlag, watchdog bit}.
- R5: Address 4 bit 0 holds the watchdog bit. When the bit is set, an overflow drives `wdResetReq` high for the one cycle after the overflow edge. When the bit is clear, an overflow leaves `wdResetReq` low.
- R6: Address 0 bits [1:0] select the output mode. Code 0 is toggle: each overflow inverts `tmrOut`.
- R7: Code 1 forces `tmrOut` low at each overflow. Code 2 forces it high at each overflow. Changing the mode by itself does not move the pin in these modes.
- R8: Code 3 is PWM. The counter wraps to 0, and `tmrOut` equals (count < reload value) XOR address 1 bit 0.
- R9: Synchronous reset clears all registers, the count and the flags, and drives `tmrOut` low.
- R10: `tmrOutEn` follows address 0 bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cntEn | input | 1 | Prescaled count strobe |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Read data for `addr`, combinational |
| tmrOut | output | 1 | Timer waveform pin |
| tmrOutEn | output | 1 | Pin drive enable |
| irqFlag | output | 1 | Sticky overflow interrupt request |
| wdResetReq | output | 1 | One-cycle watchdog reset request |

## Verification
The bench provokes three pairs of events that can fall on the same edge, with the counter held at 8'hFF and a register write issued together with the count strobe. The first pair is a flag clear with an overflow; the flag must stay set. The second is a restart with a count step; the restart value must win and no flag may be raised. The third is a reload commit with an overflow; the counter must load the previous reload value, while the readback already shows the new one. Sweeps over several reload values and three full PWM periods compare each count, flag and pin value against values the bench computes arithmetically.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'd0,
    MODE_LOW    = 2'd1,
    MODE_HIGH   = 2'd2,
    MODE_PWM    = 2'd3
  } outMode_e;

  typedef struct packed {
    logic     restart;
    outMode_e mode;
    logic     pwmInv;
  } tmrCtl_t;

  localparam logic [2:0] ADR_MODE   = 3'd0;
  localparam logic [2:0] ADR_PWMCFG = 3'd1;
  localparam logic [2:0] ADR_RLO    = 3'd2;
  localparam logic [2:0] ADR_RHI    = 3'd3;
  localparam logic [2:0] ADR_CTRL   = 3'd4;
  localparam logic [2:0] ADR_CNTLO  = 3'd5;
  localparam logic [2:0] ADR_CNTHI  = 3'd6;
endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int NIB_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [NIB_W-1:0] wrData,
  input  logic [CNT_W-1:0] count,
  input  logic             ovf,
  output tmrCtl_t          ctl,
  output logic [CNT_W-1:0] reloadVal,
  output logic [NIB_W-1:0] rdData,
  output logic             outEnable,
  output logic             irqFlag,
  output logic             wdResetReq
);
  outMode_e         modeReg;
  logic             outEnReg;
  logic             invReg;
  logic [NIB_W-1:0] stageLo;
  logic             wdEnable;

  logic ctrlWrite, clearStrobe, restartStrobe;
  assign ctrlWrite     = wrEn && (addr == ADR_CTRL);
  assign clearStrobe   = ctrlWrite && wrData[1];
  assign restartStrobe = ctrlWrite && wrData[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg   <= MODE_TOGGLE;
      outEnReg  <= 1'b0;
      invReg    <= 1'b0;
      stageLo   <= '0;
      reloadVal <= '0;
      wdEnable  <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        ADR_MODE: begin
          modeReg  <= outMode_e'(wrData[1:0]);
          outEnReg <= wrData[2];
        end
        ADR_PWMCFG: invReg    <= wrData[0];
        ADR_RLO:    stageLo   <= wrData;
        ADR_RHI:    reloadVal <= {wrData, stageLo};
        ADR_CTRL:   wdEnable  <= wrData[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqFlag    <= 1'b0;
      wdResetReq <= 1'b0;
    end else begin
      if (ovf)              irqFlag <= 1'b1;
      else if (clearStrobe) irqFlag <= 1'b0;
      wdResetReq <= ovf && wdEnable;
    end
  end

  assign ctl.restart = restartStrobe;
  assign ctl.mode    = modeReg;
  assign ctl.pwmInv  = invReg;
  assign outEnable   = outEnReg;

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_MODE:   rdData = NIB_W'({outEnReg, modeReg});
      ADR_PWMCFG: rdData = NIB_W'(invReg);
      ADR_RLO:    rdData = reloadVal[NIB_W-1:0];
      ADR_RHI:    rdData = reloadVal[CNT_W-1:NIB_W];
      ADR_CTRL:   rdData = NIB_W'({irqFlag, wdEnable});
      ADR_CNTLO:  rdData = count[NIB_W-1:0];
      ADR_CNTHI:  rdData = count[CNT_W-1:NIB_W];
      default:    rdData = '0;
    endcase
  end

  // R4: the flag only drops after a clear write.
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irqFlag) |-> $past(clearStrobe));
  // R5: a reset request needs an overflow with the watchdog armed.
  assert_wd_cause_R5: assert property (@(posedge clk) disable iff (rst)
    wdResetReq |-> $past(ovf && wdEnable));
endmodule

// File: rtl/reload_timer_dp.sv
module reload_timer_dp
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  tmrCtl_t          ctl,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             pinOut
);
  logic             isPwm, atMax, outReg;
  logic [CNT_W-1:0] startVal;

  assign isPwm    = (ctl.mode == MODE_PWM);
  assign atMax    = (count == {CNT_W{1'b1}});
  assign startVal = isPwm ? '0 : reloadVal;
  assign ovf      = cntEn && atMax && !ctl.restart;

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (ctl.restart) count <= startVal;
    else if (cntEn)       count <= atMax ? startVal : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) outReg <= 1'b0;
    else if (ovf) begin
      case (ctl.mode)
        MODE_TOGGLE: outReg <= ~outReg;
        MODE_LOW:    outReg <= 1'b0;
        MODE_HIGH:   outReg <= 1'b1;
        default:     outReg <= outReg;
      endcase
    end
  end

  assign pinOut = isPwm ? ((count < reloadVal) ^ ctl.pwmInv) : outReg;

  // R1: the count moves only on a strobe or a restart.
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> $past(cntEn || ctl.restart));
  // R2: an overflow in a timer mode reloads the committed value.
  assert_reload_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ovf && !isPwm) |=> (count == $past(reloadVal)));
  // R7: drive-high mode leaves the pin high after an overflow.
  assert_drive_high_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf && ctl.mode == MODE_HIGH) |=> outReg);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int NIB_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [NIB_W-1:0] wrData,
  output logic [NIB_W-1:0] rdData,
  output logic             tmrOut,
  output logic             tmrOutEn,
  output logic             irqFlag,
  output logic             wdResetReq
);
  tmrCtl_t          ctl;
  logic [CNT_W-1:0] reloadVal, count;
  logic             ovf;

  reload_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .ovf(ovf), .ctl(ctl), .reloadVal(reloadVal),
    .rdData(rdData), .outEnable(tmrOutEn), .irqFlag(irqFlag),
    .wdResetReq(wdResetReq)
  );

  reload_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .cntEn(cntEn), .ctl(ctl), .reloadVal(reloadVal),
    .count(count), .ovf(ovf), .pinOut(tmrOut)
  );
endmodule

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntEn = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wrData = '0;
  logic [3:0] rdData;
  logic       tmrOut, tmrOutEn, irqFlag, wdResetReq;

  int checks = 0;
  int errors = 0;
  logic expOut = 1'b0;
  logic wdSel = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst(rst), .cntEn(cntEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tmrOut(tmrOut), .tmrOutEn(tmrOutEn),
    .irqFlag(irqFlag), .wdResetReq(wdResetReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doStep(input logic w, input logic [2:0] a, input logic [3:0] d, input logic c);
    wrEn = w; addr = a; wrData = d; cntEn = c;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; cntEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) doStep(1'b0, 3'd0, 4'd0, 1'b1);
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [3:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic getCount(output logic [7:0] c);
    logic [3:0] lo, hi;
    rdReg(3'd5, lo); rdReg(3'd6, hi);
    c = {hi, lo};
  endtask

  task automatic setReload(input logic [7:0] v);
    doStep(1'b1, 3'd2, v[3:0], 1'b0);
    doStep(1'b1, 3'd3, v[7:4], 1'b0);
  endtask

  task automatic ctrlWr(input logic clr, input logic rs, input logic c);
    doStep(1'b1, 3'd4, {1'b0, rs, clr, wdSel}, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] v;
    logic [7:0] c;
    logic [7:0] rl [4];
    rl[0] = 8'hF0; rl[1] = 8'hFE; rl[2] = 8'hFF; rl[3] = 8'hA5;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 pin", tmrOut, 0);
    chk("R9 flag", irqFlag, 0);
    chk("R9 wdreq", wdResetReq, 0);
    chk("R10 outEn reset", tmrOutEn, 0);
    getCount(c); chk("R9 count", c, 0);
    rdReg(3'd3, v); chk("R9 reload hi", v, 0);

    // R1 counting and holding
    tick(3);
    getCount(c); chk("R1 count after 3", c, 3);
    doStep(1'b0, 3'd0, 4'd0, 1'b0);
    doStep(1'b0, 3'd0, 4'd0, 1'b0);
    getCount(c); chk("R1 hold", c, 3);

    // R3 staging and commit
    doStep(1'b1, 3'd2, 4'h5, 1'b0);
    rdReg(3'd2, v); chk("R3 staged not visible", v, 0);
    doStep(1'b1, 3'd3, 4'hA, 1'b0);
    rdReg(3'd2, v); chk("R3 commit lo", v, 4'h5);
    rdReg(3'd3, v); chk("R3 commit hi", v, 4'hA);
    getCount(c); chk("R3 count untouched", c, 3);

    // R2 R4 R6 sweep over reload values in toggle mode
    for (int i = 0; i < 4; i++) begin
      setReload(rl[i]);
      ctrlWr(1'b1, 1'b1, 1'b0);
      getCount(c); chk("R2 restart loads reload", c, rl[i]);
      tick(255 - rl[i]);
      getCount(c); chk("R1 reach max", c, 8'hFF);
      chk("R4 no flag before overflow", irqFlag, 0);
      chk("R6 pin before overflow", tmrOut, expOut);
      tick(1);
      expOut = ~expOut;
      getCount(c); chk("R2 reload on overflow", c, rl[i]);
      chk("R4 flag on overflow", irqFlag, 1);
      chk("R6 toggle", tmrOut, expOut);
      doStep(1'b0, 3'd0, 4'd0, 1'b0);
      chk("R4 flag sticky", irqFlag, 1);
      rdReg(3'd4, v); chk("R4 flag readback", v, 4'b0010);
      ctrlWr(1'b1, 1'b0, 1'b0);
      chk("R4 flag cleared", irqFlag, 0);
    end

    // R4 clear and overflow on the same edge
    setReload(8'hFE);
    ctrlWr(1'b0, 1'b1, 1'b0);
    tick(1);
    ctrlWr(1'b1, 1'b0, 1'b1);
    expOut = ~expOut;
    chk("R4 overflow beats clear", irqFlag, 1);
    chk("R6 toggle concurrent", tmrOut, expOut);
    ctrlWr(1'b1, 1'b0, 1'b0);
    chk("R4 clear alone", irqFlag, 0);

    // R2 restart and count on the same edge
    tick(1);
    getCount(c); chk("R2 at max", c, 8'hFF);
    ctrlWr(1'b0, 1'b1, 1'b1);
    getCount(c); chk("R2 restart priority", c, 8'hFE);
    chk("R2 restart no overflow", irqFlag, 0);
    chk("R6 restart no toggle", tmrOut, expOut);

    // R3 commit and overflow on the same edge
    tick(1);
    doStep(1'b1, 3'd3, 4'h7, 1'b1);
    expOut = ~expOut;
    getCount(c); chk("R3 overflow uses old reload", c, 8'hFE);
    rdReg(3'd3, v); chk("R3 new hi committed", v, 4'h7);
    ctrlWr(1'b1, 1'b0, 1'b0);
    setReload(8'hFE);

    // R7 drive high / drive low, R10 enable
    doStep(1'b1, 3'd0, 4'b0110, 1'b0);
    chk("R10 outEn set", tmrOutEn, 1);
    chk("R7 mode change keeps pin", tmrOut, expOut);
    ctrlWr(1'b0, 1'b1, 1'b0); tick(2);
    chk("R7 drive high", tmrOut, 1);
    tick(2);
    chk("R7 drive high again", tmrOut, 1);
    doStep(1'b1, 3'd0, 4'b0001, 1'b0);
    chk("R10 outEn clear", tmrOutEn, 0);
    chk("R7 mode change no move", tmrOut, 1);
    tick(2);
    chk("R7 drive low", tmrOut, 0);
    tick(2);
    chk("R7 drive low again", tmrOut, 0);
    ctrlWr(1'b1, 1'b0, 1'b0);

    // R5 watchdog
    wdSel = 1'b1;
    ctrlWr(1'b0, 1'b1, 1'b0);
    rdReg(3'd4, v); chk("R5 wd bit readback", v, 4'b0001);
    tick(1);
    chk("R5 no request at max", wdResetReq, 0);
    tick(1);
    chk("R5 request after overflow", wdResetReq, 1);
    doStep(1'b0, 3'd0, 4'd0, 1'b0);
    chk("R5 one cycle only", wdResetReq, 0);
    ctrlWr(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk("R5 kicked no request", wdResetReq, 0);
      ctrlWr(1'b0, 1'b1, 1'b0);
      chk("R5 kicked no request after restart", wdResetReq, 0);
    end
    chk("R5 kicked no flag", irqFlag, 0);
    wdSel = 1'b0;
    ctrlWr(1'b0, 1'b1, 1'b0);
    tick(2);
    chk("R5 disarmed no request", wdResetReq, 0);
    chk("R5 disarmed flag", irqFlag, 1);
    ctrlWr(1'b1, 1'b0, 1'b0);

    // R8 PWM sweeps
    doStep(1'b1, 3'd0, 4'b0011, 1'b0);
    setReload(8'h40);
    ctrlWr(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 256; k++) begin
      chk("R8 pwm duty 40", tmrOut, (k < 8'h40) ? 1 : 0);
      tick(1);
    end
    getCount(c); chk("R8 wrap to zero", c, 0);
    chk("R8 overflow flag", irqFlag, 1);
    doStep(1'b1, 3'd1, 4'd1, 1'b0);
    setReload(8'h00);
    ctrlWr(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 256; k++) begin
      chk("R8 pwm inverted duty 0", tmrOut, 1);
      tick(1);
    end
    doStep(1'b1, 3'd1, 4'd0, 1'b0);
    setReload(8'hC3);
    ctrlWr(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 256; k++) begin
      chk("R8 pwm duty C3", tmrOut, (k < 8'hC3) ? 1 : 0);
      tick(1);
    end

    // R9 reset forces pin low
    doStep(1'b1, 3'd0, 4'b0110, 1'b0);
    setReload(8'hFF);
    ctrlWr(1'b0, 1'b1, 1'b0);
    tick(1);
    chk("R7 high before reset", tmrOut, 1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 pin low after reset", tmrOut, 0);
    chk("R9 flag after reset", irqFlag, 0);
    rdReg(3'd0, v); chk("R9 mode after reset", v, 0);
    rdReg(3'd2, v); chk("R9 reload after reset", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule